// File: doc/BRIEF.md
# Flash Erase Command Decoder

This block is the command front end of a parallel NOR-style flash memory model. It watches single-cycle bus writes (address, byte, write strobe) and recognises the six-write unlock sequences that request a whole-array erase or a per-sector erase. A sector request opens an acceptance window. While the window is open, more sectors can be queued. When the window runs out, an embedded erase engine sweeps the on-chip array and sets every word of the queued sectors to all ones.

Reads use the same address bus. In read-array mode a read returns the stored word. While a sector queue is open or an erase is running, a read returns a status byte instead. The status byte carries a data-poll bit, two toggle bits and a bit that shows whether erasure has begun. A registered ready line falls for the whole busy period. A synchronous hardware reset abandons any sequence or erase and restores read-array mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `ready` is 1 and the block is in read-array mode. A read returns the word at `bus_addr` on `rd_data` one clock after the `bus_re` cycle. At power-up, word a holds the low 7 bits of a, so bit 7 is 0.
- R2: The command prefix is five writes: 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, then 0x55 at 0x2AA. A write with a wrong address or wrong data at any step silently returns the decoder to read-array mode.
- R3: A sixth write of 0x10 at 0x555 starts an erase of every sector at once, with no acceptance window. Afterwards every word reads 0xFF.
- R4: A sixth write of 0x30 at any address queues the sector selected by the top address bits (256-word sectors) and opens a window of WIN_CYCLES clocks. If no sector write is accepted before the window expires, erase of the queued sectors starts and `ready` later returns to 1.
- R5: Each further 0x30 write during the window queues its sector and restarts the window. A 0x30 write on the very clock the window would expire is accepted, and erase does not start on that clock.
- R6: A 0xB0 write during the window neither discards the queue nor restarts the window.
- R7: Any other write during the window discards the queue and returns to read-array mode at once. No sector is erased.
- R8: `ready` is 0 from the write that opens a window or starts a whole-array erase until the erase finishes.
- R9: While a window is open or an erase is running, reads return a status byte. Bit 7 is 0 and bit 3 is 0 in the window and 1 once erasure has begun. Bits 5, 4, 1 and 0 are 0.
- R10: Status bit 6 inverts on every status read. Status bit 2 inverts on status reads whose address lies in a queued sector, and it holds on status reads to other sectors.
- R11: Writes made while the erase runs are ignored, including a complete whole-array erase sequence.
- R12: A hardware reset during an erase stops it at once. `ready` returns to 1, and words the sweep had not reached keep their contents.
- R13: When the erase finishes, the block returns to read-array mode and the sector queue is cleared. A sector discarded earlier stays intact through later erases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_addr | input | ADDR_W (11) | Word address for reads and writes |
| bus_wdata | input | 8 | Write data (command byte) |
| bus_we | input | 1 | One-cycle write strobe |
| bus_re | input | 1 | One-cycle read strobe |
| rd_data | output | 8 | Array word or status byte, valid the clock after `bus_re` |
| ready | output | 1 | 1 when idle, 0 while a window is open or an erase runs |

## Verification
The window counter reaching its last clock and a new sector-erase write can land on the same edge. In that case the decoder must decide between starting the erase and accepting the extra sector. The bench places the extra 0x30 write exactly WIN_CYCLES clocks after the previous one, by counting negative edges from the end of that write. It then judges the result in two ways. An immediate status read must still show bit 3 at 0. After completion, both the first and the late sector must read 0xFF while a neighbouring sector keeps its pattern.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_KEY1    = 8'hAA;
  localparam logic [7:0] CMD_KEY2    = 8'h55;
  localparam logic [7:0] CMD_SETUP   = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECT    = 8'h30;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;

  localparam int KEY_ADDR1 = 'h555;
  localparam int KEY_ADDR2 = 'h2AA;

  typedef enum logic [2:0] {
    ST_READ,
    ST_PRE1,
    ST_PRE2,
    ST_PRE3,
    ST_PRE4,
    ST_PRE5,
    ST_WINDOW,
    ST_ERASE
  } cmd_state_t;

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int NUM_SECT   = 8,
  parameter int WIN_CYCLES = 50
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                eng_busy,
  input  logic                eng_done,
  output logic                erase_start,
  output logic [NUM_SECT-1:0] sect_mask,
  output logic                in_window,
  output logic                in_erase,
  output logic                ready
);

  localparam int SECT_BITS = $clog2(NUM_SECT);
  localparam int CNT_W     = $clog2(WIN_CYCLES + 1);

  cmd_state_t          state_q, state_d;
  logic [NUM_SECT-1:0] mask_q, mask_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                start_q, start_d;
  logic                ready_q;

  logic                at_key1, at_key2;
  logic [NUM_SECT-1:0] wr_onehot;

  assign at_key1   = (wr_addr == ADDR_W'(KEY_ADDR1));
  assign at_key2   = (wr_addr == ADDR_W'(KEY_ADDR2));
  assign wr_onehot = NUM_SECT'(1) << wr_addr[ADDR_W-1 -: SECT_BITS];

  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    cnt_d   = cnt_q;
    start_d = 1'b0;
    case (state_q)
      ST_READ:
        if (wr_en && at_key1 && wr_data == CMD_KEY1) state_d = ST_PRE1;
      ST_PRE1:
        if (wr_en) state_d = (at_key2 && wr_data == CMD_KEY2) ? ST_PRE2 : ST_READ;
      ST_PRE2:
        if (wr_en) state_d = (at_key1 && wr_data == CMD_SETUP) ? ST_PRE3 : ST_READ;
      ST_PRE3:
        if (wr_en) state_d = (at_key1 && wr_data == CMD_KEY1) ? ST_PRE4 : ST_READ;
      ST_PRE4:
        if (wr_en) state_d = (at_key2 && wr_data == CMD_KEY2) ? ST_PRE5 : ST_READ;
      ST_PRE5:
        if (wr_en) begin
          if (at_key1 && wr_data == CMD_CHIP) begin
            mask_d  = '1;
            start_d = 1'b1;
            state_d = ST_ERASE;
          end else if (wr_data == CMD_SECT) begin
            mask_d  = wr_onehot;
            cnt_d   = CNT_W'(WIN_CYCLES);
            state_d = ST_WINDOW;
          end else begin
            state_d = ST_READ;
          end
        end
      ST_WINDOW:
        if (wr_en && wr_data == CMD_SECT) begin
          mask_d = mask_q | wr_onehot;
          cnt_d  = CNT_W'(WIN_CYCLES);
        end else if (wr_en && wr_data != CMD_SUSPEND) begin
          mask_d  = '0;
          state_d = ST_READ;
        end else if (cnt_q == CNT_W'(1)) begin
          start_d = 1'b1;
          state_d = ST_ERASE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      ST_ERASE:
        if (eng_done) begin
          mask_d  = '0;
          state_d = ST_READ;
        end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_READ;
      mask_q  <= '0;
      cnt_q   <= '0;
      start_q <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
      ready_q <= !(state_d == ST_WINDOW || state_d == ST_ERASE);
    end
  end

  assign erase_start = start_q;
  assign sect_mask   = mask_q;
  assign in_window   = (state_q == ST_WINDOW);
  assign in_erase    = (state_q == ST_ERASE);
  assign ready       = ready_q;

  AST_ENGINE_IN_ERASE: assert property (@(posedge clk) disable iff (rst)
    eng_busy |-> state_q == ST_ERASE); // R11

  AST_WINDOW_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_WINDOW |-> (cnt_q != '0 && cnt_q <= CNT_W'(WIN_CYCLES))); // R4

  AST_SECTOR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WINDOW && wr_en && wr_data == CMD_SECT)
      |=> (state_q == ST_WINDOW && cnt_q == CNT_W'(WIN_CYCLES))); // R5

  AST_OTHER_ABORTS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WINDOW && wr_en && wr_data != CMD_SECT && wr_data != CMD_SUSPEND)
      |=> (state_q == ST_READ && mask_q == '0)); // R7

  AST_ERASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERASE && !eng_done) |=> state_q == ST_ERASE); // R11

endmodule

// File: rtl/flash_erase_array.sv
module flash_erase_array #(
  parameter int ADDR_W   = 11,
  parameter int NUM_SECT = 8,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [NUM_SECT-1:0] mask,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_q,
  output logic                busy,
  output logic                done
);

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int SECT_BITS = $clog2(NUM_SECT);

  logic [DATA_W-1:0]   mem [DEPTH];
  logic [ADDR_W-1:0]   scan_q;
  logic                busy_q;
  logic [NUM_SECT-1:0] mask_q;
  logic                at_last;
  logic                wr_hit;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(i & 'h7F);
  end

  assign at_last = (scan_q == ADDR_W'(DEPTH - 1));
  assign wr_hit  = busy_q && mask_q[scan_q[ADDR_W-1 -: SECT_BITS]];

  always_ff @(posedge clk) begin
    if (wr_hit) mem[scan_q] <= '1;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      scan_q <= '0;
      mask_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      scan_q <= '0;
      mask_q <= mask;
    end else if (busy_q) begin
      if (at_last) busy_q <= 1'b0;
      scan_q <= scan_q + ADDR_W'(1);
    end
  end

  assign busy = busy_q;
  assign done = busy_q && at_last;

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy_q); // R11

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !at_last) |=> (busy_q && scan_q == $past(scan_q) + ADDR_W'(1))); // R4

endmodule

// File: rtl/flash_status.sv
module flash_status #(
  parameter int NUM_SECT = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic [$clog2(NUM_SECT)-1:0]  rd_sect,
  input  logic                         in_window,
  input  logic                         in_erase,
  input  logic [NUM_SECT-1:0]          sect_mask,
  input  logic [7:0]                   array_q,
  output logic [7:0]                   rd_data
);

  logic       show_q;
  logic [7:0] stat_q;
  logic       tog6_q, tog2_q;
  logic       busy_mode;

  assign busy_mode = in_window || in_erase;

  always_ff @(posedge clk) begin
    if (rst) begin
      show_q <= 1'b0;
      stat_q <= '0;
      tog6_q <= 1'b0;
      tog2_q <= 1'b0;
    end else if (rd_en) begin
      show_q <= busy_mode;
      if (busy_mode) begin
        stat_q <= {1'b0, tog6_q, 2'b00, in_erase, tog2_q, 2'b00};
        tog6_q <= ~tog6_q;
        if (sect_mask[rd_sect]) tog2_q <= ~tog2_q;
      end
    end
  end

  assign rd_data = show_q ? stat_q : array_q;

  AST_STATUS_DQ3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && in_window) |=> (show_q && !rd_data[3])); // R9

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W     = 11,
  parameter int NUM_SECT   = 8,
  parameter int WIN_CYCLES = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        rd_data,
  output logic              ready
);

  localparam int SECT_BITS = $clog2(NUM_SECT);

  logic                erase_start;
  logic [NUM_SECT-1:0] sect_mask;
  logic                in_window, in_erase;
  logic                eng_busy, eng_done;
  logic [7:0]          array_q;

  flash_cmd_fsm #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .WIN_CYCLES(WIN_CYCLES)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .wr_en(bus_we), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .eng_busy(eng_busy), .eng_done(eng_done),
    .erase_start(erase_start), .sect_mask(sect_mask),
    .in_window(in_window), .in_erase(in_erase), .ready(ready)
  );

  flash_erase_array #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .DATA_W(8)
  ) u_array (
    .clk(clk), .rst(rst),
    .start(erase_start), .mask(sect_mask),
    .rd_en(bus_re), .rd_addr(bus_addr), .rd_q(array_q),
    .busy(eng_busy), .done(eng_done)
  );

  flash_status #(
    .NUM_SECT(NUM_SECT)
  ) u_status (
    .clk(clk), .rst(rst),
    .rd_en(bus_re), .rd_sect(bus_addr[ADDR_W-1 -: SECT_BITS]),
    .in_window(in_window), .in_erase(in_erase), .sect_mask(sect_mask),
    .array_q(array_q), .rd_data(rd_data)
  );

endmodule

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;

  localparam int ADDR_W = 11;
  localparam int WIN    = 50;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_wdata = '0;
  logic              bus_we = 1'b0;
  logic              bus_re = 1'b0;
  logic [7:0]        rd_data;
  logic              ready;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(ADDR_W), .NUM_SECT(8), .WIN_CYCLES(WIN)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .rd_data(rd_data), .ready(ready)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    bus_addr = ADDR_W'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    bus_addr = ADDR_W'(a); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = rd_data;
  endtask

  task automatic prefix();
    wr('h555, 8'hAA); wr('h2AA, 8'h55); wr('h555, 8'h80);
    wr('h555, 8'hAA); wr('h2AA, 8'h55);
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!ready && n < 10000) begin @(negedge clk); n++; end
    chk(req, {7'd0, ready}, 8'd1);
  endtask

  function automatic logic [7:0] orig(input int a);
    return 8'(a & 'h7F);
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 ready after reset", {7'd0, ready}, 8'd1);
    rd('h123, d); chk("R1 array read", d, orig('h123));
  endtask

  task automatic t_bad_prefix();
    logic [7:0] d;
    wr('h555, 8'hAA); wr('h2AB, 8'h55);
    wr('h555, 8'hAA); wr('h2AA, 8'h55); wr('h555, 8'h90);
    wr('h555, 8'hAA); wr('h2AA, 8'h55); wr('h555, 8'h80); wr('h554, 8'hAA);
    chk("R2 ready after bad prefix", {7'd0, ready}, 8'd1);
    rd('h0A5, d); chk("R2 still read mode", d, orig('h0A5));
  endtask

  task automatic t_single_sector();
    logic [7:0] a, b;
    prefix(); wr('h210, 8'h30);
    chk("R8 ready low in window", {7'd0, ready}, 8'd0);
    rd('h000, a); rd('h000, b);
    chk("R9 window status bit3/bit7/zero bits", a & 8'hBB, 8'h00);
    chk("R10 bit6 flips", (a ^ b) & 8'h40, 8'h40);
    repeat (WIN + 5) @(negedge clk);
    rd('h000, a); chk("R9 erasing bit3 set", a & 8'hBB, 8'h08);
    chk("R8 ready low in erase", {7'd0, ready}, 8'd0);
    wait_ready("R4 erase completes");
    rd('h200, a); chk("R4 sector start erased", a, 8'hFF);
    rd('h2FF, a); chk("R4 sector end erased", a, 8'hFF);
    rd('h305, a); chk("R4 next sector intact", a, orig('h305));
    rd('h1FF, a); chk("R4 prior sector intact", a, orig('h1FF));
  endtask

  task automatic t_collision();
    logic [7:0] a;
    prefix(); wr('h400, 8'h30);
    repeat (WIN - 1) @(negedge clk);
    wr('h5A0, 8'h30);
    rd('h000, a); chk("R5 write on expiry wins, still window", a & 8'h08, 8'h00);
    wait_ready("R5 erase completes");
    rd('h4C3, a); chk("R5 first sector erased", a, 8'hFF);
    rd('h511, a); chk("R5 late sector erased", a, 8'hFF);
    rd('h611, a); chk("R5 neighbour intact", a, orig('h611));
  endtask

  task automatic t_abort();
    logic [7:0] a;
    prefix(); wr('h100, 8'h30); wr('h100, 8'hF0);
    chk("R7 ready after abort", {7'd0, ready}, 8'd1);
    rd('h105, a); chk("R7 array read after abort", a, orig('h105));
    repeat (2 * WIN) @(negedge clk);
    rd('h105, a); chk("R7 sector not erased", a, orig('h105));
  endtask

  task automatic t_suspend();
    logic [7:0] a;
    prefix(); wr('h300, 8'h30);
    repeat (WIN - 6) @(negedge clk);
    wr('h000, 8'hB0);
    chk("R6 suspend keeps window", {7'd0, ready}, 8'd0);
    repeat (6) @(negedge clk);
    rd('h000, a); chk("R6 window not restarted", a & 8'h08, 8'h08);
    wait_ready("R6 erase completes");
    rd('h3AB, a); chk("R6 queue kept", a, 8'hFF);
  endtask

  task automatic t_ignore_in_erase();
    logic [7:0] a, b;
    prefix(); wr('h010, 8'h30);
    repeat (WIN + 2) @(negedge clk);
    rd('h020, a); rd('h020, b);
    chk("R10 bit2 flips in erasing sector", (a ^ b) & 8'h04, 8'h04);
    rd('h620, a); rd('h620, b);
    chk("R10 bit2 holds elsewhere", (a ^ b) & 8'h04, 8'h00);
    chk("R10 bit6 flips", (a ^ b) & 8'h40, 8'h40);
    prefix(); wr('h555, 8'h10);
    wait_ready("R11 erase completes");
    rd('h0FF, a); chk("R11 queued sector erased", a, 8'hFF);
    rd('h611, a); chk("R11 chip erase ignored", a, orig('h611));
    rd('h105, a); chk("R13 discarded sector intact", a, orig('h105));
  endtask

  task automatic t_reset_mid();
    logic [7:0] a;
    prefix(); wr('h700, 8'h30);
    repeat (WIN + 10) @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R12 ready after reset", {7'd0, ready}, 8'd1);
    rd('h7F0, a); chk("R12 unreached word kept", a, orig('h7F0));
    rd('h700, a); chk("R12 read mode", a, orig('h700));
  endtask

  task automatic t_chip();
    logic [7:0] a;
    prefix(); wr('h555, 8'h10);
    rd('h000, a); chk("R3 no window, bit3 set", a & 8'hBB, 8'h08);
    wait_ready("R3 chip erase completes");
    rd('h611, a); chk("R3 word erased", a, 8'hFF);
    rd('h7F0, a); chk("R3 last sector erased", a, 8'hFF);
    rd('h105, a); chk("R3 first sectors erased", a, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bad_prefix();
    t_single_sector();
    t_collision();
    t_abort();
    t_suspend();
    t_ignore_in_erase();
    t_reset_mid();
    t_chip();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule